// File: doc/BRIEF.md
# Latch-or-Register Holding Stage

This block holds one 18-bit word for a single direction of a transceiver: 16 data bits and one parity bit for each of the two data bytes. A level-sensitive latch-enable control and a capture-clock control choose what the stored word does. It can follow the input word, keep its current value, or take a new value on a rising capture-clock edge. An active-low output enable decides whether the held word is presented downstream.

The block runs entirely on a fast system clock. The latch enable and the capture clock are asynchronous to that clock. Each passes through a flop synchronizer, and the capture-clock rising edge is found from the synchronized samples. The data and parity inputs are assumed to be synchronous to the system clock and are sampled directly. A disabled (high-impedance) output is modelled as a valid flag that is low, with the data and parity outputs driven to zero.

The output is a level-held stream with a valid flag and no ready input. The consumer cannot apply back-pressure. The word stays on the outputs for as long as the valid flag stays high, and a consumer takes it whenever it needs it.

Top module: `latch_reg_stage`

## Requirements
- R1: The stored word is 18 bits. Data bits 15:0 appear on `dout`. Parity bit k on `pin[k]` belongs to data byte k (bits 8k+7:8k) and appears unchanged on `pout[k]`.
- R2: Once the synchronized latch enable is high, the stored word reloads from `din`/`pin` on every system clock edge, whatever the capture clock does. After `le_in` rises, the outputs show the input word from the third clock edge on. After that, each input change appears one edge later.
- R3: While the synchronized latch enable is low, a low-to-high change of `cap_clk_in` stores the current input word. The stored value changes on the third system clock edge after the change on `cap_clk_in`.
- R4: While the latch enable is low and no capture-clock rising edge occurs, the stored word does not change. Input changes, the capture clock staying high, and a falling capture clock all leave it unchanged.
- R5: If the latch enable falls while the capture clock is already high, the word present when the latch closes is kept. No capture happens until the capture clock goes low and then high again.
- R6: `out_valid` follows the inverse of `oe_n` one clock edge later. While `out_valid` is 0, `dout` and `pout` are 0.
- R7: Disabling the outputs does not change the stored word. Once the outputs are enabled again, the same word is shown.
- R8: A synchronous active-low reset clears the stored word to zero and clears `out_valid`. After reset is released with `oe_n` low and the latch enable low, the outputs show zero with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| le_in | input | 1 | Latch enable, asynchronous, high = transparent |
| cap_clk_in | input | 1 | Capture clock, asynchronous; rising edge stores while latch is closed |
| oe_n | input | 1 | Output enable, active low |
| din | input | 16 | Data input word |
| pin | input | 2 | Byte parity inputs, bit k for byte k |
| dout | output | 16 | Held data, zero while disabled |
| pout | output | 2 | Held parity, zero while disabled |
| out_valid | output | 1 | Output enabled flag (models the driven, not high-impedance, state) |

## Verification
The hardest situation to reach is the latch closing while the capture clock is already high. Here the stage must not treat the high clock as a fresh edge. The stimulus raises the capture clock during transparent mode and lets it settle through the synchronizer. It then drops the latch enable and changes the input. Only after a full low-then-high cycle of the capture clock does it expect the new word. The three-edge latency through the synchronizer and edge detector is checked by sampling one edge before and one edge after the expected update.

// File: rtl/hold_stage_pkg.sv
package hold_stage_pkg;
  typedef enum logic [1:0] {
    HM_HOLD = 2'd0,
    HM_PASS = 2'd1,
    HM_CAPT = 2'd2
  } hold_mode_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hold_stage_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       le_s,
  input  logic       cap_s,
  output hold_mode_e mode,
  output logic       cap_rise
);
  logic cap_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cap_prev_q <= 1'b0;
    else        cap_prev_q <= cap_s;
  end

  assign cap_rise = cap_s & ~cap_prev_q;

  always_comb begin
    if (le_s)          mode = HM_PASS;
    else if (cap_rise) mode = HM_CAPT;
    else               mode = HM_HOLD;
  end
endmodule

// File: rtl/hs_store.sv
module hs_store
  import hold_stage_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hold_mode_e        mode,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (mode)
        HM_PASS, HM_CAPT: q <= d;
        default:          q <= q;
      endcase
    end
  end
endmodule

// File: rtl/hs_gate.sv
module hs_gate #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] word_out,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= ~oe_n;
  end

  assign word_out = valid ? word : '0;
endmodule

// File: rtl/latch_reg_stage.sv
module latch_reg_stage
  import hold_stage_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     le_in,
  input  logic                     cap_clk_in,
  input  logic                     oe_n,
  input  logic [DATA_W-1:0]        din,
  input  logic [DATA_W/BYTE_W-1:0] pin,
  output logic [DATA_W-1:0]        dout,
  output logic [DATA_W/BYTE_W-1:0] pout,
  output logic                     out_valid
);
  localparam int PAR_W  = DATA_W / BYTE_W;
  localparam int WORD_W = DATA_W + PAR_W;

  logic              le_s;
  logic              cap_s;
  logic              cap_rise;
  hold_mode_e        mode;
  logic [WORD_W-1:0] word_in;
  logic [WORD_W-1:0] store_q;
  logic [WORD_W-1:0] out_word;

  assign word_in = {pin, din};

  hs_sync #(.STAGES(SYNC_STAGES)) u_le_sync (
    .clk(clk), .rst_n(rst_n), .d(le_in), .q(le_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_clk_in), .q(cap_s)
  );

  hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .le_s(le_s), .cap_s(cap_s),
    .mode(mode), .cap_rise(cap_rise)
  );

  hs_store #(.WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .d(word_in), .q(store_q)
  );

  hs_gate #(.WORD_W(WORD_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .word(store_q),
    .word_out(out_word), .valid(out_valid)
  );

  assign dout = out_word[DATA_W-1:0];
  assign pout = out_word[WORD_W-1:DATA_W];
endmodule

// File: rtl/latch_reg_stage_chk.sv
module latch_reg_stage_chk
  import hold_stage_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input hold_mode_e        mode,
  input logic              cap_rise,
  input logic [WORD_W-1:0] word_in,
  input logic [WORD_W-1:0] store_q,
  input logic [WORD_W-1:0] out_word,
  input logic              out_valid
);
  AST_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_PASS) |=> (store_q == $past(word_in))); // R2

  AST_CAPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_CAPT) |=> (store_q == $past(word_in))); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HM_HOLD) |=> $stable(store_q)); // R4

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> !cap_rise); // R5

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (out_valid == !$past(oe_n))); // R6

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == '0)); // R6

  AST_ON_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word == store_q)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (store_q == '0 && !out_valid)); // R8
endmodule

bind latch_reg_stage latch_reg_stage_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .mode(mode), .cap_rise(cap_rise),
  .word_in(word_in), .store_q(store_q), .out_word(out_word),
  .out_valid(out_valid)
);

// File: tb/latch_reg_stage_tb.sv
module latch_reg_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        le_in = 1'b0;
  logic        cap_clk_in = 1'b0;
  logic        oe_n = 1'b0;
  logic [15:0] din = '0;
  logic [1:0]  pin = '0;
  logic [15:0] dout;
  logic [1:0]  pout;
  logic        out_valid;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  latch_reg_stage u_dut (
    .clk(clk), .rst_n(rst_n), .le_in(le_in), .cap_clk_in(cap_clk_in),
    .oe_n(oe_n), .din(din), .pin(pin), .dout(dout), .pout(pout),
    .out_valid(out_valid)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [17:0] exp_w, input logic exp_v);
    total++;
    if ({pout, dout} !== exp_w || out_valid !== exp_v) begin
      bad++;
      $display("FAIL %s: got word=%05h valid=%b, expected word=%05h valid=%b",
               req, {pout, dout}, out_valid, exp_w, exp_v);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; le_in = 1'b0; cap_clk_in = 1'b0; oe_n = 1'b0;
    din = 16'hFFFF; pin = 2'b11;
    edges(3);
    check("R8 in reset", 18'h0, 1'b0);
    rst_n = 1'b1;
    edges(3);
    check("R8 after release", 18'h0, 1'b1);
  endtask

  task automatic t_transparent();
    le_in = 1'b1; din = 16'hA55A; pin = 2'b01;
    edges(2);
    check("R2 before third edge", 18'h0, 1'b1);
    edges(1);
    check("R2 third edge", {2'b01, 16'hA55A}, 1'b1);
    din = 16'h1234; pin = 2'b10;
    edges(1);
    check("R2 follow", {2'b10, 16'h1234}, 1'b1);
    cap_clk_in = 1'b1; din = 16'h00FF; pin = 2'b10;
    edges(4);
    check("R1 byte parity order", {2'b10, 16'h00FF}, 1'b1);
    cap_clk_in = 1'b0;
    edges(3);
  endtask

  task automatic t_hold_capture();
    din = 16'hBEEF; pin = 2'b11;
    edges(1);
    le_in = 1'b0;
    edges(4);
    check("R4 closed latch keeps", {2'b11, 16'hBEEF}, 1'b1);
    din = 16'h0F0F; pin = 2'b00;
    edges(5);
    check("R4 input change ignored", {2'b11, 16'hBEEF}, 1'b1);
    din = 16'hC001; pin = 2'b01;
    cap_clk_in = 1'b1;
    edges(2);
    check("R3 before capture", {2'b11, 16'hBEEF}, 1'b1);
    edges(1);
    check("R3 capture", {2'b01, 16'hC001}, 1'b1);
    din = 16'h7777; pin = 2'b10;
    edges(5);
    check("R4 clock held high", {2'b01, 16'hC001}, 1'b1);
    cap_clk_in = 1'b0;
    edges(5);
    check("R4 falling clock", {2'b01, 16'hC001}, 1'b1);
  endtask

  task automatic t_close_high();
    le_in = 1'b1; cap_clk_in = 1'b1; din = 16'h5A5A; pin = 2'b11;
    edges(5);
    check("R5 open with clock high", {2'b11, 16'h5A5A}, 1'b1);
    le_in = 1'b0;
    edges(3);
    din = 16'h9999; pin = 2'b00;
    edges(5);
    check("R5 no capture on close", {2'b11, 16'h5A5A}, 1'b1);
    cap_clk_in = 1'b0;
    edges(4);
    check("R5 clock low", {2'b11, 16'h5A5A}, 1'b1);
    cap_clk_in = 1'b1;
    edges(3);
    check("R5 next rise captures", {2'b00, 16'h9999}, 1'b1);
  endtask

  task automatic t_output_enable();
    oe_n = 1'b1;
    edges(1);
    check("R6 disabled", 18'h0, 1'b0);
    cap_clk_in = 1'b0;
    edges(3);
    din = 16'h4321; pin = 2'b01;
    edges(2);
    check("R7 disabled still zero", 18'h0, 1'b0);
    oe_n = 1'b0;
    edges(1);
    check("R7 contents kept", {2'b00, 16'h9999}, 1'b1);
  endtask

  task automatic t_mid_reset();
    rst_n = 1'b0;
    edges(2);
    check("R8 mid-run reset", 18'h0, 1'b0);
    rst_n = 1'b1;
    edges(1);
    check("R8 cleared word", 18'h0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold_capture();
    t_close_high();
    t_output_enable();
    t_mid_reset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule